// File: doc/BRIEF.md
# Round-Robin Per-Band Adaptive State Store

This block holds the adaptive state of a multi-lane hyperspectral predictor. Samples arrive pixel by pixel with every band of a pixel in sequence. A fixed number of compression lanes work on the bands of one pixel side by side, so each pixel is handled as a short series of groups. In group `g`, lane `k` works on band `g*LANES + k`. Each lane therefore owns every LANES-th band. It keeps the state of those bands (a vector of prediction weights and an error accumulator) in a small circulating store. The entry at the head is shown to the lane while that band is processed. The lane's updated copy is written back into the rotation, so the same band appears again one pixel later.

After an initialisation request, the block loads every entry of every lane with the starting weights and starting accumulator. It then reports ready and steps through the groups each time the caller signals a step. When the band count is not a multiple of the lane count, the lanes that have no band in the last group of a pixel are flagged idle. Their stores neither advance nor take the update. The block also produces the sample index used to schedule accumulator rescaling, which all lanes share. This index is derived from the pixel column and row and saturates at a configured limit.

The default configuration has 3 lanes and 8 bands. That gives 3 groups per pixel, and lane 2 is idle in the last group.

Top module: `band_state_store`

## Requirements
- R1: After reset `ready_o` is 0 and `sample_cnt_o` is 0. `ready_o` stays 0 until an initialisation request is seen. After the clock edge that samples `init_req_i` high, `ready_o` goes to 1 after exactly ceil(BANDS/LANES) further clock edges, provided no new request arrives in that time.
- R2: While ready, lane k shows band number `g*LANES + k` on `lane_band_o[k]`, where g is the current group. g starts at 0. Each edge with `step_valid_i` high advances g by one, and g returns to 0 after group ceil(BANDS/LANES)-1.
- R3: `lane_idle_o[k]` is 1 exactly when `g*LANES + k >= BANDS`. The update a lane presents while idle is ignored: no stored band value changes because of it.
- R4: On the first pixel after initialisation, every band shows the weight vector from `init_wgt_i` and the accumulator from `init_acc_i`.
- R5: The weights and accumulator given on `upd_wgt_i[k]`/`upd_acc_i[k]` at a step edge for band b are the values shown for band b at the next pixel.
- R6: An edge with `step_valid_i` low, or any edge while not ready, changes neither the group nor any stored or shown state.
- R7: `sample_cnt_o` equals the pixel index `x + y*NX` of the current pixel. It is 0 on the first pixel after initialisation, rises by one each time a pixel's last group is stepped, and saturates at CNT_LIMIT.
- R8: `init_req_i` takes priority over everything else, including an initialisation already in progress and a step in the same cycle. It drops `ready_o` on the next edge, restarts the load, and returns the group and the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req_i | input | 1 | Start of image: reload all band state |
| init_wgt_i | input | NW*WW | Starting weight vector loaded for every band |
| init_acc_i | input | AW | Starting accumulator loaded for every band |
| step_valid_i | input | 1 | Current group is processed this cycle |
| upd_wgt_i | input | LANES*NW*WW | Updated weights returned by each lane |
| upd_acc_i | input | LANES*AW | Updated accumulator returned by each lane |
| ready_o | output | 1 | State is loaded and groups may be stepped |
| lane_band_o | output | LANES*BW | Band number each lane works on |
| lane_idle_o | output | LANES | Lane has no band in this group |
| lane_wgt_o | output | LANES*NW*WW | Weight vector for each lane's band |
| lane_acc_o | output | LANES*AW | Accumulator for each lane's band |
| sample_cnt_o | output | CW | Shared saturating pixel index |

## Verification
The bound checker tests the following on every cycle:
- an initialisation request drops ready on the next edge;
- a cycle without a step leaves the band numbers and the shown accumulators unchanged;
- band numbers advance by the lane count or wrap to zero;
- the shared counter never exceeds its limit and moves by at most one.

Three behaviours need the bench's behavioural band-indexed model and its scenarios:
- the return of each band's update one pixel later, which shows the rotation order is kept;
- the exclusion of updates from idle lanes;
- the reload of fresh values after an initialisation restarted mid-image and again mid-load.

// File: rtl/bss_pkg.sv
package bss_pkg;

    typedef enum logic [1:0] {
        SEQ_UNINIT = 2'd0,
        SEQ_LOAD   = 2'd1,
        SEQ_RUN    = 2'd2
    } seq_state_e;

    function automatic int bits_for(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/bss_sequencer.sv
module bss_sequencer
    import bss_pkg::*;
#(
    parameter int LANES     = 3,
    parameter int BANDS     = 8,
    parameter int NX        = 4,
    parameter int CNT_LIMIT = 10,
    localparam int DEPTH    = ceil_div(BANDS, LANES),
    localparam int GW       = bits_for(DEPTH),
    localparam int CW       = bits_for(CNT_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_req_i,
    input  logic          step_valid_i,
    output logic          ready_o,
    output logic          step_o,
    output logic          load_we_o,
    output logic [GW-1:0] load_idx_o,
    output logic [GW-1:0] grp_o,
    output logic [CW-1:0] cnt_o
);
    localparam int XW   = bits_for(NX);
    localparam int YMAX = CNT_LIMIT / NX + 1;
    localparam int YW   = bits_for(YMAX + 1);
    localparam int PW   = YW + bits_for(NX + 1) + 2;

    typedef struct packed {
        seq_state_e    st;
        logic [GW-1:0] idx;
        logic [GW-1:0] grp;
        logic [XW-1:0] x;
        logic [YW-1:0] y;
    } seq_t;

    seq_t          s_d, s_q;
    logic [PW-1:0] pos;

    always_comb begin
        s_d       = s_q;
        load_we_o = 1'b0;
        unique case (s_q.st)
            SEQ_LOAD: begin
                load_we_o = 1'b1;
                if (s_q.idx == GW'(DEPTH - 1)) s_d.st = SEQ_RUN;
                else                           s_d.idx = s_q.idx + 1'b1;
            end
            SEQ_RUN: begin
                if (step_valid_i) begin
                    if (s_q.grp == GW'(DEPTH - 1)) begin
                        s_d.grp = '0;
                        if (s_q.x == XW'(NX - 1)) begin
                            s_d.x = '0;
                            if (s_q.y != YW'(YMAX)) s_d.y = s_q.y + 1'b1;
                        end else begin
                            s_d.x = s_q.x + 1'b1;
                        end
                    end else begin
                        s_d.grp = s_q.grp + 1'b1;
                    end
                end
            end
            default: ;
        endcase
        if (init_req_i) begin
            s_d.st  = SEQ_LOAD;
            s_d.idx = '0;
            s_d.grp = '0;
            s_d.x   = '0;
            s_d.y   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_UNINIT, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_o    = (s_q.st == SEQ_RUN);
    assign step_o     = ready_o && step_valid_i && !init_req_i;
    assign load_idx_o = s_q.idx;
    assign grp_o      = s_q.grp;
    assign pos        = PW'(s_q.y) * PW'(NX) + PW'(s_q.x);
    assign cnt_o      = (pos > PW'(CNT_LIMIT)) ? CW'(CNT_LIMIT) : pos[CW-1:0];

endmodule

// File: rtl/bss_lane_store.sv
module bss_lane_store
    import bss_pkg::*;
#(
    parameter int LANE   = 0,
    parameter int LANES  = 3,
    parameter int BANDS  = 8,
    parameter int NW     = 3,
    parameter int WW     = 8,
    parameter int AW     = 10,
    localparam int DEPTH = ceil_div(BANDS, LANES),
    localparam int GW    = bits_for(DEPTH),
    localparam int BW    = bits_for(DEPTH * LANES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_we_i,
    input  logic [GW-1:0]          load_idx_i,
    input  logic [NW-1:0][WW-1:0]  load_wgt_i,
    input  logic [AW-1:0]          load_acc_i,
    input  logic                   step_i,
    input  logic [GW-1:0]          grp_i,
    input  logic [NW-1:0][WW-1:0]  upd_wgt_i,
    input  logic [AW-1:0]          upd_acc_i,
    output logic [BW-1:0]          band_o,
    output logic                   idle_o,
    output logic [NW-1:0][WW-1:0]  wgt_o,
    output logic [AW-1:0]          acc_o
);
    localparam int OWN = ceil_div(BANDS - LANE, LANES);

    typedef struct packed {
        logic [GW-1:0] ptr;
    } lane_t;

    lane_t                  l_d, l_q;
    logic                   wr_en;
    logic [GW-1:0]          wr_addr;
    logic [NW-1:0][WW-1:0]  wr_wgt;
    logic [AW-1:0]          wr_acc;
    logic [NW-1:0][WW-1:0]  wgt_mem [DEPTH];
    logic [AW-1:0]          acc_mem [DEPTH];

    assign band_o = BW'(int'(grp_i) * LANES + LANE);
    assign idle_o = (int'(grp_i) * LANES + LANE) >= BANDS;

    always_comb begin
        l_d     = l_q;
        wr_en   = 1'b0;
        wr_addr = l_q.ptr;
        wr_wgt  = upd_wgt_i;
        wr_acc  = upd_acc_i;
        if (load_we_i) begin
            l_d.ptr = '0;
            wr_en   = 1'b1;
            wr_addr = load_idx_i;
            wr_wgt  = load_wgt_i;
            wr_acc  = load_acc_i;
        end else if (step_i && !idle_o) begin
            wr_en   = 1'b1;
            l_d.ptr = (l_q.ptr == GW'(OWN - 1)) ? '0 : l_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            wgt_mem[wr_addr] <= wr_wgt;
            acc_mem[wr_addr] <= wr_acc;
        end
    end

    assign wgt_o = wgt_mem[l_q.ptr];
    assign acc_o = acc_mem[l_q.ptr];

endmodule

// File: rtl/band_state_store.sv
module band_state_store
    import bss_pkg::*;
#(
    parameter int LANES     = 3,
    parameter int BANDS     = 8,
    parameter int NX        = 4,
    parameter int CNT_LIMIT = 10,
    parameter int NW        = 3,
    parameter int WW        = 8,
    parameter int AW        = 10,
    localparam int DEPTH    = ceil_div(BANDS, LANES),
    localparam int BW       = bits_for(DEPTH * LANES),
    localparam int CW       = bits_for(CNT_LIMIT + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              init_req_i,
    input  logic [NW-1:0][WW-1:0]             init_wgt_i,
    input  logic [AW-1:0]                     init_acc_i,
    input  logic                              step_valid_i,
    input  logic [LANES-1:0][NW-1:0][WW-1:0]  upd_wgt_i,
    input  logic [LANES-1:0][AW-1:0]          upd_acc_i,
    output logic                              ready_o,
    output logic [LANES-1:0][BW-1:0]          lane_band_o,
    output logic [LANES-1:0]                  lane_idle_o,
    output logic [LANES-1:0][NW-1:0][WW-1:0]  lane_wgt_o,
    output logic [LANES-1:0][AW-1:0]          lane_acc_o,
    output logic [CW-1:0]                     sample_cnt_o
);
    localparam int GW = bits_for(DEPTH);

    logic          step;
    logic          load_we;
    logic [GW-1:0] load_idx;
    logic [GW-1:0] grp;

    bss_sequencer #(
        .LANES(LANES), .BANDS(BANDS), .NX(NX), .CNT_LIMIT(CNT_LIMIT)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_req_i   (init_req_i),
        .step_valid_i (step_valid_i),
        .ready_o      (ready_o),
        .step_o       (step),
        .load_we_o    (load_we),
        .load_idx_o   (load_idx),
        .grp_o        (grp),
        .cnt_o        (sample_cnt_o)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        bss_lane_store #(
            .LANE(k), .LANES(LANES), .BANDS(BANDS), .NW(NW), .WW(WW), .AW(AW)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_we_i  (load_we),
            .load_idx_i (load_idx),
            .load_wgt_i (init_wgt_i),
            .load_acc_i (init_acc_i),
            .step_i     (step),
            .grp_i      (grp),
            .upd_wgt_i  (upd_wgt_i[k]),
            .upd_acc_i  (upd_acc_i[k]),
            .band_o     (lane_band_o[k]),
            .idle_o     (lane_idle_o[k]),
            .wgt_o      (lane_wgt_o[k]),
            .acc_o      (lane_acc_o[k])
        );
    end

endmodule

// File: rtl/band_state_store_chk.sv
module band_state_store_chk
    import bss_pkg::*;
#(
    parameter int LANES     = 3,
    parameter int BANDS     = 8,
    parameter int CNT_LIMIT = 10,
    parameter int AW        = 10,
    parameter int BW        = 4,
    parameter int CW        = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     init_req_i,
    input logic                     step_valid_i,
    input logic                     ready_o,
    input logic [LANES-1:0][BW-1:0] lane_band_o,
    input logic [LANES-1:0][AW-1:0] lane_acc_o,
    input logic [CW-1:0]            sample_cnt_o
);
    AST_INIT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        init_req_i |=> !ready_o); // R8

    AST_HOLD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !step_valid_i && !init_req_i) |=> $stable(lane_band_o)); // R6

    AST_HOLD_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !step_valid_i && !init_req_i) |=> $stable(lane_acc_o)); // R6

    AST_BAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && step_valid_i && !init_req_i) |=>
        ((lane_band_o[0] == '0) || (lane_band_o[0] == $past(lane_band_o[0]) + BW'(LANES)))); // R2

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        sample_cnt_o <= CW'(CNT_LIMIT)); // R7

    AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !init_req_i) |=>
        ((sample_cnt_o == $past(sample_cnt_o)) || (sample_cnt_o == $past(sample_cnt_o) + 1'b1))); // R7

endmodule

bind band_state_store band_state_store_chk #(
    .LANES(LANES), .BANDS(BANDS), .CNT_LIMIT(CNT_LIMIT), .AW(AW), .BW(BW), .CW(CW)
) u_chk (.*);

// File: tb/band_state_store_bench.sv
module band_state_store_bench;
    import bss_pkg::*;

    localparam int LANES = 3, BANDS = 8, NX = 4, LIMIT = 10, NW = 3, WW = 8, AW = 10;
    localparam int DEPTH = ceil_div(BANDS, LANES);
    localparam int BW = bits_for(DEPTH * LANES);
    localparam int CW = bits_for(LIMIT + 1);

    logic clk = 0, rst_n = 0, init_req = 0, step_valid = 0;
    logic [NW-1:0][WW-1:0] init_wgt = '0;
    logic [AW-1:0] init_acc = '0;
    logic [LANES-1:0][NW-1:0][WW-1:0] upd_wgt = '0;
    logic [LANES-1:0][AW-1:0] upd_acc = '0;
    logic ready;
    logic [LANES-1:0][BW-1:0] lane_band;
    logic [LANES-1:0] lane_idle;
    logic [LANES-1:0][NW-1:0][WW-1:0] lane_wgt;
    logic [LANES-1:0][AW-1:0] lane_acc;
    logic [CW-1:0] sample_cnt;

    always #2.5 clk = ~clk;

    band_state_store #(.LANES(LANES), .BANDS(BANDS), .NX(NX), .CNT_LIMIT(LIMIT),
                       .NW(NW), .WW(WW), .AW(AW)) u_band_state_store (
        .clk(clk), .rst_n(rst_n), .init_req_i(init_req), .init_wgt_i(init_wgt),
        .init_acc_i(init_acc), .step_valid_i(step_valid), .upd_wgt_i(upd_wgt),
        .upd_acc_i(upd_acc), .ready_o(ready), .lane_band_o(lane_band),
        .lane_idle_o(lane_idle), .lane_wgt_o(lane_wgt), .lane_acc_o(lane_acc),
        .sample_cnt_o(sample_cnt));

    int checks = 0, errors = 0;
    bit done = 0, cmp_on = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural model indexed by band
    logic [NW*WW-1:0] m_w [BANDS];
    logic [AW-1:0]    m_a [BANDS];
    bit m_fresh [BANDS];
    bit m_ready = 0, m_loading = 0, m_hold = 0;
    int m_lcnt = 0, m_g = 0, m_pix = 0;

    always @(posedge clk) begin
        m_hold = 0;
        if (!rst_n) begin
            m_ready = 0; m_loading = 0; m_lcnt = 0; m_g = 0; m_pix = 0;
        end else if (init_req) begin
            m_loading = 1; m_lcnt = 0; m_ready = 0; m_g = 0; m_pix = 0;
        end else if (m_loading) begin
            m_lcnt++;
            if (m_lcnt == DEPTH) begin
                m_loading = 0; m_ready = 1;
                for (int b = 0; b < BANDS; b++) begin
                    m_w[b] = init_wgt; m_a[b] = init_acc; m_fresh[b] = 1;
                end
            end
        end else if (m_ready) begin
            if (step_valid) begin
                for (int k = 0; k < LANES; k++) begin
                    if (m_g * LANES + k < BANDS) begin
                        m_w[m_g * LANES + k] = upd_wgt[k];
                        m_a[m_g * LANES + k] = upd_acc[k];
                        m_fresh[m_g * LANES + k] = 0;
                    end
                end
                if (m_g == DEPTH - 1) begin m_g = 0; m_pix++; end
                else m_g++;
            end else begin
                m_hold = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R1", "ready", ready, m_ready);
            chk("R7", "sample_cnt", sample_cnt, (m_pix > LIMIT) ? LIMIT : m_pix);
            if (m_ready) begin
                for (int k = 0; k < LANES; k++) begin
                    int b;
                    b = m_g * LANES + k;
                    chk(m_hold ? "R6" : "R2", "lane_band", lane_band[k], b);
                    chk("R3", "lane_idle", lane_idle[k], b >= BANDS);
                    if (b < BANDS) begin
                        chk(m_fresh[b] ? "R4" : "R5", "lane_wgt", lane_wgt[k], m_w[b]);
                        chk(m_fresh[b] ? "R4" : "R5", "lane_acc", lane_acc[k], m_a[b]);
                    end
                end
            end
        end
    end

    task automatic drive_cycle(input bit stp);
        @(negedge clk); #1;
        step_valid = stp;
        for (int k = 0; k < LANES; k++) begin
            upd_wgt[k] = (NW*WW)'($urandom);
            upd_acc[k] = AW'($urandom);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        init_wgt = {8'h11, 8'h22, 8'h33};
        init_acc = 10'h155;
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", ready, 0);
        chk("R1", "cnt in reset", sample_cnt, 0);
        #1 rst_n = 1; cmp_on = 1;
        // steps before any initialisation are ignored (R6)
        for (int i = 0; i < 4; i++) drive_cycle(1);
        @(negedge clk); #1 init_req = 1;
        @(negedge clk); #1 init_req = 0;
        chk("R8", "ready after request", ready, 0);
        for (int i = 0; i < DEPTH + 2; i++) drive_cycle(1); // steps during load ignored
        // main run with gaps; passes counter limit
        for (int i = 0; i < 60; i++) drive_cycle((i % 5) != 3);
        // restart mid-image, then again while loading (R8)
        for (int i = 0; i < 2; i++) drive_cycle(1);
        init_wgt = {8'hA5, 8'h5A, 8'hC3};
        init_acc = 10'h2AA;
        @(negedge clk); #1 init_req = 1; step_valid = 1;
        @(negedge clk);
        chk("R8", "ready after restart", ready, 0);
        chk("R8", "cnt after restart", sample_cnt, 0);
        #1 init_req = 1;
        @(negedge clk); #1 init_req = 0;
        for (int i = 0; i < DEPTH + 2; i++) drive_cycle(0);
        for (int i = 0; i < 50; i++) drive_cycle((i % 7) != 6);
        drive_cycle(0);
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule